// File: doc/BRIEF.md
# Serial PMIC bus command register front-end

This block is the register face of a serial power-management bus master. Software reaches it over APB. It first fills up to four 32-bit outgoing data words, then writes one command word that carries a start bit, an opcode, a byte count minus one, a 4-bit target ID and a 16-bit register address. The block latches the command and presents it on a request/response transaction port, with the payload bytes unpacked into payload order. A separate bus engine, modelled by the bench here, answers that port. Software then polls a status word chosen by the target ID for done and fail, and collects any returned bytes from four read-data words kept for that target.

A sequencer with three states runs each command. IDLE accepts a start; a supported opcode (0 to 10) moves IDLE to WAIT (transition `go_ok`), and an opcode above 10 moves IDLE to REJECT (transition `go_bad`). WAIT holds the request until the engine acknowledges (transition `ack`, back to IDLE). REJECT always returns to IDLE after one cycle (transition `reject_done`), recording done and fail without ever raising the request. Every register lies inside a window placed at CHANNEL times 0x300, and per-target registers repeat at a stride of 0x20.

Top module: `pcb_cmd_frontend`

## Requirements
- R1: Every APB access completes in its access phase with `pready` high and `pslverr` low. After reset every register reads zero, and any offset in the window that is not a mapped register reads zero.
- R2: Writing the command register (window offset 0x100) with bit 31 set while idle and with opcode at most 10 raises `txn_req`. The request carries opcode = bits 27:24, count-minus-one = bits 23:20, target ID = bits 19:16 and address = bits 15:0, and it stays high with stable fields until the cycle `txn_ack` is sampled.
- R3: Outgoing data words live at offsets 0x104, 0x108, 0x10C and 0x110 and read back as written. Payload byte k (bits 8k+7:8k of `txn_wdata`) is taken from data word k/4, bits 31-8(k%4) down to 24-8(k%4). This is big-endian, with the first byte in bits 31:24. Bytes with k greater than the count-minus-one are zero.
- R4: Reading the command register returns bit 31 = 1 while a command is in progress and 0 once it completes. Bits 30:0 return those of the last accepted command.
- R5: A command write while a command is in progress, or any command write with bit 31 clear, is ignored. It raises no further request and changes neither the command readback nor any status.
- R6: The status word of target s sits at 0x200 + 0x20·s, with bit 0 = done and bit 2 = fail. Accepting a command clears done and fail of its target only. On completion, done is set and fail takes the engine's `txn_fail`. The status of other targets does not change.
- R7: The read-data words of target s sit at 0x204 + 0x20·s + 4·w (w = 0..3). They are loaded only when a read opcode (2, 4 or 6) completes with fail low. The load uses the big-endian packing of R3 from `txn_rdata`, with bytes beyond the count set to zero. Failed reads and all other opcodes leave them unchanged.
- R8: A command with opcode 11 to 15 never raises `txn_req`. It completes one cycle after acceptance with done and fail both set.
- R9: With CHANNEL = c, all registers are decoded only at their offsets plus 0x300·c. Addresses below that base read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | AW | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| txn_req | output | 1 | Transaction request to the engine |
| txn_op | output | 4 | Opcode of the request |
| txn_sid | output | 4 | Target ID of the request |
| txn_len | output | 4 | Byte count minus one |
| txn_addr | output | 16 | Target register address |
| txn_wdata | output | 8·4·DATA_WORDS | Payload bytes, byte k at bits 8k+7:8k |
| txn_ack | input | 1 | One-cycle completion from the engine |
| txn_fail | input | 1 | Completion failed (valid with ack) |
| txn_rdata | input | 8·4·DATA_WORDS | Returned bytes, byte k at bits 8k+7:8k |

## Verification
The assertions assume that the engine pulses `txn_ack` for exactly one cycle and only while `txn_req` is high. They also assume that `txn_fail` and `txn_rdata` are valid in that cycle. The bench engine model keeps to this: it waits for a request, stays silent for a programmed delay, and then drives ack high for one cycle with fail and data set together. Stimulus mixes seeded random opcodes (including unsupported ones), counts, targets and failure outcomes with directed cases for a command issued while busy, for start-bit-clear writes and for the channel window.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_WAIT   = 2'd1,
        S_REJECT = 2'd2
    } seq_state_e;

    localparam logic [3:0] OP_LAST = 4'd10;

    function automatic logic op_is_read(input logic [3:0] op);
        return (op == 4'd2) || (op == 4'd4) || (op == 4'd6);
    endfunction

endpackage

// File: rtl/pcb_wdata_bank.sv
module pcb_wdata_bank #(
    parameter int WORDS = 4,
    localparam int NB   = 4 * WORDS,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LW   = $clog2(NB)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IW-1:0]            widx,
    input  logic [31:0]              wval,
    input  logic [LW-1:0]            len,
    output logic [WORDS-1:0][31:0]   words,
    output logic [8*NB-1:0]          bytes_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words <= '0;
        end else if (we) begin
            words[widx] <= wval;
        end
    end

    // Big-endian unpacking, bytes past the count forced to zero
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < 4; b++) begin : g_byte
            localparam int K = 4 * w + b;
            assign bytes_out[8*K +: 8] = (int'(len) >= K) ? words[w][31-8*b -: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/pcb_seq.sv
module pcb_seq
    import pcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [3:0] go_op,
    input  logic [3:0] cur_op,
    input  logic       ack,
    input  logic       ack_fail,
    output logic       busy,
    output logic       req,
    output logic       start,
    output logic       fin,
    output logic       fin_fail,
    output logic       rd_load
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        busy     = 1'b1;
        req      = 1'b0;
        start    = 1'b0;
        fin      = 1'b0;
        fin_fail = 1'b0;
        rd_load  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
                if (go) begin
                    start   = 1'b1;
                    state_d = (go_op <= OP_LAST) ? S_WAIT : S_REJECT;
                end
            end
            S_WAIT: begin
                req = 1'b1;
                if (ack) begin
                    fin      = 1'b1;
                    fin_fail = ack_fail;
                    rd_load  = !ack_fail && op_is_read(cur_op);
                    state_d  = S_IDLE;
                end
            end
            S_REJECT: begin
                fin      = 1'b1;
                fin_fail = 1'b1;
                state_d  = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // R2: request held until the engine answers
    a_r2_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);

    // R8: a rejected opcode never leads to a request in the next cycle
    a_r8_reject_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && (go_op > OP_LAST)) |=> !req);

endmodule

// File: rtl/pcb_status_bank.sv
module pcb_status_bank #(
    parameter int NSLV  = 16,
    parameter int WORDS = 4,
    localparam int NB   = 4 * WORDS,
    localparam int LW   = $clog2(NB)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clr,
    input  logic [3:0]                         clr_sid,
    input  logic                               fin,
    input  logic                               fin_fail,
    input  logic [3:0]                         cur_sid,
    input  logic                               rd_load,
    input  logic [LW-1:0]                      rd_len,
    input  logic [8*NB-1:0]                    rd_bytes,
    output logic [NSLV-1:0]                    done,
    output logic [NSLV-1:0]                    fail,
    output logic [NSLV-1:0][WORDS-1:0][31:0]   rwords
);

    logic [WORDS-1:0][31:0] packed_rd;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < 4; b++) begin : g_byte
            localparam int K = 4 * w + b;
            assign packed_rd[w][31-8*b -: 8] = (int'(rd_len) >= K) ? rd_bytes[8*K +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= '0;
            fail   <= '0;
            rwords <= '0;
        end else begin
            if (clr) begin
                done[clr_sid] <= 1'b0;
                fail[clr_sid] <= 1'b0;
            end
            if (fin) begin
                done[cur_sid] <= 1'b1;
                fail[cur_sid] <= fin_fail;
            end
            if (rd_load) begin
                rwords[cur_sid] <= packed_rd;
            end
        end
    end

    // R6: completion marks the target done
    a_r6_fin_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done[$past(cur_sid)]);

    // R6: acceptance clears the target's status
    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!done[$past(clr_sid)] && !fail[$past(clr_sid)]));

    // R7: read data only moves on a successful read completion
    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_load |=> $stable(rwords));

endmodule

// File: rtl/pcb_cmd_frontend.sv
module pcb_cmd_frontend
    import pcb_pkg::*;
#(
    parameter int CHANNEL    = 0,
    parameter int CH_STRIDE  = 'h300,
    parameter int SLV_STRIDE = 'h20,
    parameter int NUM_SLAVES = 16,
    parameter int DATA_WORDS = 4,
    parameter int AW         = 16,
    localparam int NB        = 4 * DATA_WORDS,
    localparam int BW        = 8 * NB,
    localparam int IW        = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1,
    localparam int LW        = $clog2(NB),
    localparam int SW        = $clog2(NUM_SLAVES),
    localparam int SH        = $clog2(SLV_STRIDE)
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [31:0]   pwdata,
    output logic [31:0]   prdata,
    output logic          pready,
    output logic          pslverr,
    output logic          txn_req,
    output logic [3:0]    txn_op,
    output logic [3:0]    txn_sid,
    output logic [3:0]    txn_len,
    output logic [15:0]   txn_addr,
    output logic [BW-1:0] txn_wdata,
    input  logic          txn_ack,
    input  logic          txn_fail,
    input  logic [BW-1:0] txn_rdata
);

    localparam logic [AW-1:0] WIN_BASE = AW'(CHANNEL * CH_STRIDE);
    localparam logic [AW-1:0] OFS_CMD  = AW'('h100);
    localparam logic [AW-1:0] OFS_ST   = AW'('h200);
    localparam logic [AW-1:0] ST_END   = AW'('h200 + SLV_STRIDE * NUM_SLAVES);
    localparam logic [AW-1:0] SUB_MASK = AW'(SLV_STRIDE - 1);

    logic [30:0] cmd_q;
    logic        busy, start, fin, fin_fail, rd_load;
    logic        in_win, st_hit, wr, cmd_go, wd_we;
    logic [AW-1:0] loc, st_rel, st_sub;
    logic [SW-1:0] st_idx;
    logic [IW-1:0] wd_idx;
    logic [DATA_WORDS-1:0][31:0]             wwords;
    logic [NUM_SLAVES-1:0]                   st_done, st_fail;
    logic [NUM_SLAVES-1:0][DATA_WORDS-1:0][31:0] rwords;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // Address decode inside this channel's window
    assign in_win = (paddr >= WIN_BASE);
    assign loc    = paddr - WIN_BASE;
    assign st_hit = in_win && (loc >= OFS_ST) && (loc < ST_END);
    assign st_rel = loc - OFS_ST;
    assign st_idx = SW'(st_rel >> SH);
    assign st_sub = st_rel & SUB_MASK;
    assign wr     = psel && penable && pwrite;
    assign cmd_go = wr && in_win && (loc == OFS_CMD) && pwdata[31];

    always_comb begin
        wd_we  = 1'b0;
        wd_idx = '0;
        for (int w = 0; w < DATA_WORDS; w++) begin
            if (wr && in_win && (loc == OFS_CMD + AW'(4 * (w + 1)))) begin
                wd_we  = 1'b1;
                wd_idx = IW'(w);
            end
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            cmd_q <= '0;
        end else if (cmd_go && !busy) begin
            cmd_q <= pwdata[30:0];
        end
    end

    assign txn_op   = cmd_q[27:24];
    assign txn_len  = cmd_q[23:20];
    assign txn_sid  = cmd_q[19:16];
    assign txn_addr = cmd_q[15:0];

    pcb_seq i_seq (
        .clk      (pclk),
        .rst_n    (presetn),
        .go       (cmd_go),
        .go_op    (pwdata[27:24]),
        .cur_op   (cmd_q[27:24]),
        .ack      (txn_ack),
        .ack_fail (txn_fail),
        .busy     (busy),
        .req      (txn_req),
        .start    (start),
        .fin      (fin),
        .fin_fail (fin_fail),
        .rd_load  (rd_load)
    );

    pcb_wdata_bank #(.WORDS(DATA_WORDS)) i_wbank (
        .clk       (pclk),
        .rst_n     (presetn),
        .we        (wd_we),
        .widx      (wd_idx),
        .wval      (pwdata),
        .len       (LW'(cmd_q[23:20])),
        .words     (wwords),
        .bytes_out (txn_wdata)
    );

    pcb_status_bank #(.NSLV(NUM_SLAVES), .WORDS(DATA_WORDS)) i_sbank (
        .clk      (pclk),
        .rst_n    (presetn),
        .clr      (start),
        .clr_sid  (pwdata[19:16]),
        .fin      (fin),
        .fin_fail (fin_fail),
        .cur_sid  (cmd_q[19:16]),
        .rd_load  (rd_load),
        .rd_len   (LW'(cmd_q[23:20])),
        .rd_bytes (txn_rdata),
        .done     (st_done),
        .fail     (st_fail),
        .rwords   (rwords)
    );

    always_comb begin
        prdata = '0;
        if (in_win && (loc == OFS_CMD)) begin
            prdata = {busy, cmd_q};
        end
        for (int w = 0; w < DATA_WORDS; w++) begin
            if (in_win && (loc == OFS_CMD + AW'(4 * (w + 1)))) begin
                prdata = wwords[w];
            end
        end
        if (st_hit) begin
            if (st_sub == '0) begin
                prdata = {29'd0, st_fail[st_idx], 1'b0, st_done[st_idx]};
            end
            for (int w = 0; w < DATA_WORDS; w++) begin
                if (st_sub == AW'(4 * (w + 1))) begin
                    prdata = rwords[st_idx][w];
                end
            end
        end
    end

    // R2: request fields stay put until acknowledged
    a_r2_fields_stable: assert property (@(posedge pclk) disable iff (!presetn)
        (txn_req && !txn_ack) |=> $stable({txn_op, txn_len, txn_sid, txn_addr, txn_wdata}));

    // R8: only supported opcodes reach the engine
    a_r8_req_op_ok: assert property (@(posedge pclk) disable iff (!presetn)
        txn_req |-> (txn_op <= OP_LAST));

    // R5: a command write during a transaction leaves the command untouched
    a_r5_busy_ignores: assert property (@(posedge pclk) disable iff (!presetn)
        (cmd_go && busy) |=> $stable(cmd_q));

endmodule

// File: tb/test_pcb_cmd_frontend.sv
module test_pcb_cmd_frontend;

    localparam int CH = 1;
    localparam logic [15:0] B = 16'h0300;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [15:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        txn_req;
    logic [3:0]  txn_op, txn_sid, txn_len;
    logic [15:0] txn_addr;
    logic [127:0] txn_wdata;
    logic        txn_ack = 1'b0, txn_fail = 1'b0;
    logic [127:0] txn_rdata = '0;

    pcb_cmd_frontend #(.CHANNEL(CH)) i_pcb_cmd_frontend (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .txn_req(txn_req), .txn_op(txn_op),
        .txn_sid(txn_sid), .txn_len(txn_len), .txn_addr(txn_addr),
        .txn_wdata(txn_wdata), .txn_ack(txn_ack), .txn_fail(txn_fail),
        .txn_rdata(txn_rdata)
    );

    always #2 pclk = ~pclk;

    int errors = 0, checks = 0, req_count = 0, model_delay = 2;
    bit resp_fail = 1'b0, finished = 1'b0;
    logic [3:0]  cap_op, cap_sid, cap_len;
    logic [15:0] cap_addr;
    logic [127:0] cap_wdata, resp_bytes;
    logic [31:0] wreg [4];
    logic [31:0] exp_rd [16][4];
    bit exp_done [16];
    bit exp_fail [16];

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Engine model
    initial begin
        forever begin
            @(negedge pclk);
            if (txn_req) begin
                req_count++;
                cap_op = txn_op; cap_sid = txn_sid; cap_len = txn_len;
                cap_addr = txn_addr; cap_wdata = txn_wdata;
                resp_bytes = {$urandom, $urandom, $urandom, $urandom};
                repeat (model_delay - 1) @(negedge pclk);
                txn_fail = resp_fail; txn_rdata = resp_bytes; txn_ack = 1'b1;
                @(negedge pclk);
                txn_ack = 1'b0;
            end
        end
    end

    task automatic apb_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [15:0] a_cmd(); return B + 16'h100; endfunction
    function automatic logic [15:0] a_wd(input int w); return B + 16'h104 + 16'(4 * w); endfunction
    function automatic logic [15:0] a_st(input int s); return B + 16'h200 + 16'(32 * s); endfunction
    function automatic logic [15:0] a_rd(input int s, input int w); return a_st(s) + 16'(4 + 4 * w); endfunction

    function automatic logic [127:0] exp_wbytes(input logic [3:0] len);
        logic [127:0] r = '0;
        for (int k = 0; k < 16; k++)
            if (k <= int'(len)) r[8*k +: 8] = wreg[k/4][31-8*(k%4) -: 8];
        return r;
    endfunction

    function automatic logic [31:0] pack_word(input logic [127:0] by, input logic [3:0] len, input int w);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++)
            if (4 * w + b <= int'(len)) r[31-8*b -: 8] = by[8*(4*w+b) +: 8];
        return r;
    endfunction

    function automatic bit is_rd(input logic [3:0] op);
        return (op == 4'd2) || (op == 4'd4) || (op == 4'd6);
    endfunction

    task automatic load_wregs();
        for (int w = 0; w < 4; w++) begin
            wreg[w] = $urandom;
            apb_write(a_wd(w), wreg[w]);
        end
    endtask

    task automatic poll_done(input int s, output logic [31:0] st);
        for (int i = 0; i < 200; i++) begin
            apb_read(a_st(s), st);
            if (st[0]) break;
        end
    endtask

    task automatic after_txn(input logic [3:0] op, input logic [3:0] sid, input logic [3:0] len,
                             input logic [15:0] addr, input bit fl, input int prev,
                             input logic [31:0] cmdw);
        logic [31:0] d;
        bit ok_op = (op <= 4'd10);
        bit efail = ok_op ? fl : 1'b1;
        poll_done(int'(sid), d);
        chk(d[0] == 1'b1 && d[2] == efail && d[1] == 1'b0, "R6 status done/fail", d, {efail, 2'b01});
        if (ok_op) begin
            chk(req_count == prev + 1, "R2 one request", req_count, prev + 1);
            chk({cap_op, cap_len, cap_sid, cap_addr} == {op, len, sid, addr}, "R2 request fields",
                {cap_op, cap_len, cap_sid, cap_addr}, {op, len, sid, addr});
            chk(cap_wdata == exp_wbytes(len), "R3 payload packing", cap_wdata, exp_wbytes(len));
        end else begin
            chk(req_count == prev, "R8 no request for bad opcode", req_count, prev);
        end
        exp_done[sid] = 1'b1;
        exp_fail[sid] = efail;
        if (ok_op && !fl && is_rd(op))
            for (int w = 0; w < 4; w++) exp_rd[sid][w] = pack_word(resp_bytes, len, w);
        for (int w = 0; w < 4; w++) begin
            apb_read(a_rd(int'(sid), w), d);
            chk(d == exp_rd[sid][w], "R7 read data word", d, exp_rd[sid][w]);
        end
        apb_read(a_cmd(), d);
        chk(d == {1'b0, cmdw[30:0]}, "R4 command readback idle", d, {1'b0, cmdw[30:0]});
    endtask

    task automatic run_txn(input logic [3:0] op, input logic [3:0] sid, input logic [3:0] len,
                           input logic [15:0] addr, input bit fl, input int dly);
        logic [31:0] cmdw;
        int prev;
        load_wregs();
        resp_fail = fl; model_delay = dly;
        cmdw = {1'b1, 3'b000, op, len, sid, addr};
        prev = req_count;
        apb_write(a_cmd(), cmdw);
        after_txn(op, sid, len, addr, fl, prev, cmdw);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge pclk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d, cmdw;
        int prev;
        void'($urandom(32'h1234_5eed));
        for (int s = 0; s < 16; s++) begin
            exp_done[s] = 0; exp_fail[s] = 0;
            for (int w = 0; w < 4; w++) exp_rd[s][w] = '0;
        end
        repeat (3) @(negedge pclk);
        presetn = 1'b1;

        // Reset state and bus response (R1)
        chk(txn_req == 1'b0, "R1 no request after reset", txn_req, 0);
        apb_read(a_cmd(), d);
        chk(d == 0 && pready && !pslverr, "R1 command reset / no wait, no error", d, 0);
        apb_read(a_st(5), d);
        chk(d == 0, "R1 status reset", d, 0);
        apb_read(a_rd(15, 3), d);
        chk(d == 0, "R1 read data reset", d, 0);
        apb_write(B + 16'h0120, 32'hFFFF_FFFF);
        apb_read(B + 16'h0120, d);
        chk(d == 0, "R1 unmapped offset reads zero", d, 0);
        apb_read(a_st(0) + 16'h0014, d);
        chk(d == 0, "R1 unmapped slot in status stride", d, 0);

        // Write data readback (R3)
        load_wregs();
        for (int w = 0; w < 4; w++) begin
            apb_read(a_wd(w), d);
            chk(d == wreg[w], "R3 data word readback", d, wreg[w]);
        end

        // Channel window (R9)
        prev = req_count;
        apb_read(16'h0100, d);
        chk(d == 0, "R9 other channel command reads zero", d, 0);
        apb_write(16'h0100, 32'h8100_0000);
        repeat (4) @(negedge pclk);
        chk(req_count == prev, "R9 other channel write starts nothing", req_count, prev);
        apb_read(a_cmd(), d);
        chk(d == 0, "R9 own command untouched", d, 0);

        // Start bit clear is ignored (R5)
        apb_write(a_cmd(), 32'h0123_4567);
        repeat (4) @(negedge pclk);
        chk(req_count == prev, "R5 start bit clear no request", req_count, prev);
        apb_read(a_cmd(), d);
        chk(d == 0, "R5 start bit clear no latch", d, 0);

        // Directed: full 16-byte write, 1-byte read, 5-byte read, failure, bad opcode
        run_txn(4'd1, 4'd3, 4'd15, 16'hA5A5, 1'b0, 3);
        run_txn(4'd2, 4'd0, 4'd0, 16'h0001, 1'b0, 1);
        run_txn(4'd6, 4'd15, 4'd4, 16'hFFFF, 1'b0, 2);
        run_txn(4'd11, 4'd9, 4'd2, 16'h0042, 1'b0, 2);
        run_txn(4'd15, 4'd9, 4'd7, 16'h0043, 1'b0, 2);

        // Busy: readback, status clear, second command ignored (R4, R5, R6)
        load_wregs();
        resp_fail = 1'b0; model_delay = 30;
        cmdw = {1'b1, 3'b000, 4'd4, 4'd5, 4'd3, 16'h1357};
        prev = req_count;
        apb_write(a_cmd(), cmdw);
        apb_read(a_cmd(), d);
        chk(d[31] == 1'b1, "R4 start bit reads one while busy", d, 1);
        apb_read(a_st(3), d);
        chk(d == 0, "R6 status cleared on start", d, 0);
        apb_read(a_st(15), d);
        chk(d[0] == 1'b1, "R6 other target untouched by start", d, 1);
        apb_write(a_cmd(), {1'b1, 3'b000, 4'd1, 4'd0, 4'd7, 16'h2222});
        after_txn(4'd4, 4'd3, 4'd5, 16'h1357, 1'b0, prev, cmdw);
        apb_read(a_st(7), d);
        chk(d == 0, "R5 ignored command left target 7 idle", d, 0);

        // Failed read leaves read data (R7)
        run_txn(4'd4, 4'd3, 4'd15, 16'h0777, 1'b1, 2);

        // Seeded random mix
        for (int i = 0; i < 40; i++) begin
            run_txn(4'($urandom % 13), 4'($urandom % 16), 4'($urandom % 16),
                    16'($urandom), ($urandom % 4) == 0, 1 + int'($urandom % 6));
        end

        // Final sweep of every target (R6, R7)
        for (int s = 0; s < 16; s++) begin
            apb_read(a_st(s), d);
            chk(d == {29'd0, exp_fail[s], 1'b0, exp_done[s]}, "R6 final status sweep",
                d, {exp_fail[s], 1'b0, exp_done[s]});
            for (int w = 0; w < 4; w++) begin
                apb_read(a_rd(s, w), d);
                chk(d == exp_rd[s][w], "R7 final read data sweep", d, exp_rd[s][w]);
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule